// File: doc/BRIEF.md
# Programmable Delayed Trigger Pulse Channel

This block is one timing-signal channel that runs on a bunch-crossing clock. A launch comes from one of two places. The first is an external start, which is a trigger accept seen together with a trigger-period marker. The second is a software immediate request written into the channel's control register. After a launch the channel waits a programmed number of ticks, emits a pulse, and then returns to idle. By default the pulse is one tick wide. A parameter sets a wider pulse for the variant channel, which holds its output for eight ticks.

The channel has two launch modes. In continuous mode every external start fires the channel. In single-cycle mode an external start fires the channel only after software has armed it, and only once per arming. An immediate request sets a sticky pending flag, and so does an arming. When any pulse finishes, both flags clear together, whatever caused the pulse. Software uses a single 16-bit register port. A write takes effect on the rising clock edge that captures it, and the read data always shows the current register state. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. All pins are plain control and status.

The two trigger inputs are registered by input flops. By default these flops sample on the rising clock edge. The parameter `SAMPLE_ON_FALL` moves the sampling to the falling edge. The launch stimulus is the edge at which these flops capture both inputs high, or the rising edge at which a write is captured.

Top module: `trig_pulse_channel`

## Requirements
- R1: While reset is high at a rising edge, the output goes low, both pending flags clear and the register reads 0x0000.
- R2: An external start happens only when trig_accept and trig_period are both high at the same sampling edge. Either input high on its own launches nothing.
- R3: With delay N in register bits 3:0, the output rises on the (N+1)th rising edge after the launch stimulus. This holds for N = 0, 3, 5 and 15.
- R4: The output stays high for exactly PULSE_TICKS clock periods: 1 for the default channel and 8 for the variant. It changes only on rising edges.
- R5: Writing 1 to bit 4 sets the immediate-pending flag (read bit 8) and launches the channel after the programmed delay.
- R6: When mode bit 7 is 0, every external start that finds the channel idle launches it.
- R7: When mode bit 7 is 1, an external start launches the channel only if the single-cycle pending flag (read bit 9) is set. Writing 1 to bit 5 sets that flag. A second start after the pulse does not launch the channel.
- R8: If software writes bit 5 back to 0 after arming, the single-cycle pending flag stays set and the next external start still launches the channel.
- R9: On the rising edge where the pulse ends, both bit 8 and bit 9 clear, whatever caused the pulse. A write that sets a flag on that same edge takes priority over the clear.
- R10: A launch that arrives while a countdown or a pulse is in progress is dropped. A flag set during that time stays set until the current pulse ends, then clears, and no extra pulse follows.
- R11: Bits 15:10, 7, 6, 5, 4 and 3:0 read back as last written. Bits 9:8 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_accept | input | 1 | Trigger accept for this channel |
| trig_period | input | 1 | Trigger-period marker |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, with pending flags in bits 9:8 |
| pulse_out | output | 1 | Delayed timing pulse |

## Verification
The bench uses several kinds of external start: accept alone, period alone, both together, starts in continuous mode, and starts in single-cycle mode with and without arming. Each pattern shows whether the coincidence gate and the mode logic are working. Delays of 0, 3, 5 and 15 check the count for off-by-one errors at both ends of the field. An immediate request issued after an arming shows that the flags clear together. A start and a request issued during a countdown show whether busy launches are dropped or queued. A second instance with an eight-tick pulse checks the wide variant edge by edge.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int REG_W        = 16;
  localparam int DLY_W        = 4;
  localparam int DLY_LSB      = 0;
  localparam int IMM_BIT      = 4;
  localparam int ARM_BIT      = 5;
  localparam int MODE_BIT     = 7;
  localparam int PEND_IMM_BIT = 8;
  localparam int PEND_ARM_BIT = 9;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_HIGH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tpc_start_sync.sv
module tpc_start_sync #(
  parameter bit SAMPLE_ON_FALL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_in,
  input  logic period_in,
  output logic start
);
  logic acc_q;
  logic per_q;

  generate
    if (SAMPLE_ON_FALL) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) begin
          acc_q <= 1'b0;
          per_q <= 1'b0;
        end else begin
          acc_q <= accept_in;
          per_q <= period_in;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          acc_q <= 1'b0;
          per_q <= 1'b0;
        end else begin
          acc_q <= accept_in;
          per_q <= period_in;
        end
      end
    end
  endgenerate

  assign start = acc_q & per_q;
endmodule

// File: rtl/tpc_ctrl_reg.sv
module tpc_ctrl_reg
  import tpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pulse_done,
  output logic [DLY_W-1:0] delay,
  output logic             single_mode,
  output logic             imm_pend,
  output logic             arm_pend,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] FLAG_MASK =
    (REG_W'(1) << PEND_IMM_BIT) | (REG_W'(1) << PEND_ARM_BIT);

  logic [REG_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (wr_en) begin
      store_q <= wr_data & ~FLAG_MASK;
    end
  end

  // set beats clear when both land on one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      imm_pend <= 1'b0;
    end else if (wr_en && wr_data[IMM_BIT]) begin
      imm_pend <= 1'b1;
    end else if (pulse_done) begin
      imm_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_pend <= 1'b0;
    end else if (wr_en && wr_data[ARM_BIT]) begin
      arm_pend <= 1'b1;
    end else if (pulse_done) begin
      arm_pend <= 1'b0;
    end
  end

  assign delay       = store_q[DLY_LSB +: DLY_W];
  assign single_mode = store_q[MODE_BIT];

  always_comb begin
    rd_data               = store_q;
    rd_data[PEND_IMM_BIT] = imm_pend;
    rd_data[PEND_ARM_BIT] = arm_pend;
  end
endmodule

// File: rtl/tpc_sequencer.sv
module tpc_sequencer
  import tpc_pkg::*;
#(
  parameter int PULSE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [DLY_W-1:0] delay,
  output logic             pulse,
  output logic             done
);
  localparam int WC_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [WC_W-1:0] WC_LOAD = WC_W'(PULSE_TICKS - 1);

  seq_state_e       state_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [WC_W-1:0]  wcnt_q;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (launch) begin
            if (delay == '0) begin
              state_q <= SEQ_HIGH;
              pulse_q <= 1'b1;
              wcnt_q  <= WC_LOAD;
            end else begin
              state_q <= SEQ_WAIT;
              dcnt_q  <= delay - 1'b1;
            end
          end
        end
        SEQ_WAIT: begin
          if (dcnt_q == '0) begin
            state_q <= SEQ_HIGH;
            pulse_q <= 1'b1;
            wcnt_q  <= WC_LOAD;
          end else begin
            dcnt_q <= dcnt_q - 1'b1;
          end
        end
        SEQ_HIGH: begin
          if (wcnt_q == '0) begin
            state_q <= SEQ_IDLE;
            pulse_q <= 1'b0;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          pulse_q <= 1'b0;
        end
      endcase
    end
  end

  assign pulse = pulse_q;
  assign done  = (state_q == SEQ_HIGH) && (wcnt_q == '0);
endmodule

// File: rtl/trig_pulse_channel.sv
module trig_pulse_channel
  import tpc_pkg::*;
#(
  parameter int PULSE_TICKS    = 1,
  parameter bit SAMPLE_ON_FALL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_accept,
  input  logic             trig_period,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             pulse_out
);
  logic             ext_start;
  logic             pulse_done;
  logic [DLY_W-1:0] delay;
  logic             single_mode;
  logic             imm_pend;
  logic             arm_pend;
  logic             launch;

  tpc_start_sync #(.SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .accept_in (trig_accept),
    .period_in (trig_period),
    .start     (ext_start)
  );

  tpc_ctrl_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (reg_wr),
    .wr_data     (reg_wdata),
    .pulse_done  (pulse_done),
    .delay       (delay),
    .single_mode (single_mode),
    .imm_pend    (imm_pend),
    .arm_pend    (arm_pend),
    .rd_data     (reg_rdata)
  );

  // the sequencer itself ignores launch unless idle
  assign launch = imm_pend | (ext_start & (~single_mode | arm_pend));

  tpc_sequencer #(.PULSE_TICKS(PULSE_TICKS)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .delay  (delay),
    .pulse  (pulse_out),
    .done   (pulse_done)
  );
endmodule

// File: rtl/tpc_chk.sv
module tpc_chk #(
  parameter int PULSE_TICKS = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        pulse_out
);
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 0;
    else if (pulse_out) run_q <= run_q + 1;
    else run_q <= 0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pulse_out && rd_data == 16'h0000));

  // R4
  width_max_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> (run_q < PULSE_TICKS));

  // R4
  width_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_out) |-> (run_q == PULSE_TICKS));

  // R5
  imm_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[8]) |-> $past(wr_en && wr_data[4]));

  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_out) && !$past(wr_en)) |-> (rd_data[9:8] == 2'b00));
endmodule

bind trig_pulse_channel tpc_chk #(.PULSE_TICKS(PULSE_TICKS)) u_tpc_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (reg_wr),
  .wr_data   (reg_wdata),
  .rd_data   (reg_rdata),
  .pulse_out (pulse_out)
);

// File: tb/tb_trig_pulse_channel.sv
`timescale 1ns/1ps
module tb_trig_pulse_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc = 1'b0, per = 1'b0, wen = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        pout;
  logic        w_acc = 1'b0, w_per = 1'b0, w_wen = 1'b0;
  logic [15:0] w_wd = '0;
  logic [15:0] w_rd;
  logic        w_pout;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int rises = 0;
  int rise_cyc = 0;
  int cur_dly = 0;
  int exp_q[$];
  logic prev_p = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_pulse_channel dut (
    .clk(clk), .rst(rst), .trig_accept(acc), .trig_period(per),
    .reg_wr(wen), .reg_wdata(wd), .reg_rdata(rd), .pulse_out(pout));

  trig_pulse_channel #(.PULSE_TICKS(8)) dut_w8 (
    .clk(clk), .rst(rst), .trig_accept(w_acc), .trig_period(w_per),
    .reg_wr(w_wen), .reg_wdata(w_wd), .reg_rdata(w_rd), .pulse_out(w_pout));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: compares each rise against the queued cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (pout && !prev_p) begin
        rises++;
        rise_cyc = cyc;
        if (exp_q.size() == 0) chk("R10 unexpected pulse", cyc, -1);
        else chk("R3 rise edge", cyc, exp_q.pop_front());
      end
      if (!pout && prev_p) chk("R4 pulse width", cyc - rise_cyc, 1);
    end
    prev_p = pout;
  end

  task automatic ext_start(input bit expect_launch);
    @(negedge clk);
    acc = 1'b1; per = 1'b1;
    if (expect_launch) exp_q.push_back(cyc + 1 + cur_dly + 1);
    @(negedge clk);
    acc = 1'b0; per = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d, input bit expect_launch);
    @(negedge clk);
    wen = 1'b1; wd = d;
    cur_dly = int'(d[3:0]);
    if (expect_launch) exp_q.push_back(cyc + 1 + cur_dly + 1);
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int base;
    int pat;
    int exp_pat;
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset output", pout, 0);
    chk("R1 reset register", rd, 16'h0000);
    rst = 1'b0;

    // R2: each input alone does nothing
    wr(16'h0003, 0);
    base = rises;
    @(negedge clk); acc = 1'b1; @(negedge clk); acc = 1'b0;
    idle(2);
    @(negedge clk); per = 1'b1; @(negedge clk); per = 1'b0;
    @(negedge clk); acc = 1'b1; @(negedge clk); acc = 1'b0; per = 1'b1;
    @(negedge clk); per = 1'b0;
    idle(10);
    chk("R2 single input no launch", rises, base);

    // R3/R6 continuous mode, delay 3, twice
    ext_start(1); idle(8);
    ext_start(1); idle(8);
    chk("R6 every start launches", rises, base + 2);

    // R3 delay 0 and 15
    wr(16'h0000, 0); ext_start(1); idle(5);
    wr(16'h000F, 0); ext_start(1); idle(22);

    // R5 immediate request, delay 5
    wr(16'h0015, 1);
    chk("R5 pending imm set", rd[8], 1);
    idle(10);
    chk("R9 pending imm cleared", rd[8], 0);
    chk("R11 bit4 reads written", rd[4], 1);
    wr(16'h0005, 0);

    // R7 single-cycle mode, delay 2
    base = rises;
    wr(16'h0082, 0);
    ext_start(0); idle(6);
    chk("R7 unarmed start ignored", rises, base);
    wr(16'h00A2, 0);
    chk("R7 arm sets pending", rd[9], 1);
    wr(16'h0082, 0);
    chk("R8 pending kept after bit5 clear", rd[9], 1);
    chk("R8 bit5 reads 0", rd[5], 0);
    ext_start(1); idle(6);
    chk("R8 armed start launches", rises, base + 1);
    chk("R9 arm pending cleared", rd[9], 0);
    ext_start(0); idle(6);
    chk("R7 second start ignored", rises, base + 1);

    // R9 immediate pulse clears arm pending too
    wr(16'h00A2, 0);
    wr(16'h0092, 1);
    idle(6);
    chk("R9 both flags clear", rd[9:8], 0);
    ext_start(0); idle(6);
    chk("R9 arm gone, no launch", rises, base + 2);

    // R10 launches during countdown are dropped
    wr(16'h0006, 0);
    base = rises;
    ext_start(1);
    wr(16'h0016, 0);
    cur_dly = 6;
    chk("R10 pending set while busy", rd[8], 1);
    ext_start(0);
    idle(10);
    chk("R10 pending cleared at pulse end", rd[8], 0);
    chk("R10 exactly one pulse", rises, base + 1);
    wr(16'h0006, 0);
    idle(4);
    chk("R10 no late pulse", rises, base + 1);

    // R11 readback, flags ignore writes
    wr(16'hFF40, 0);
    idle(1);
    chk("R11 readback", rd, 16'hFC40);
    wr(16'h0000, 0);
    idle(3);
    chk("R11 no pulse from readback write", rises, base + 1);

    // R4 wide variant: delay 1, eight ticks high
    @(negedge clk); w_wen = 1'b1; w_wd = 16'h0001;
    @(negedge clk); w_wen = 1'b0;
    @(negedge clk); w_acc = 1'b1; w_per = 1'b1; s = cyc + 1;
    pat = 0; exp_pat = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      w_acc = 1'b0; w_per = 1'b0;
      if (w_pout) pat |= (1 << i);
      if (cyc >= s + 2 && cyc <= s + 9) exp_pat |= (1 << i);
    end
    chk("R4 variant eight-tick pulse", pat, exp_pat);

    idle(3);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule